// File: doc/BRIEF.md
# Instruction Dispatcher with Hardware Repeat

This block sits in a control processor and feeds six processing units, each over its own 10-bit instruction bus that carries a valid strobe. It holds twenty-one 10-bit instruction registers in three banks of seven. Each bank is shared by one pair of units: units 0 and 1 read bank 0, units 2 and 3 read bank 1, and units 4 and 5 read bank 2. Software preloads the banks through a simple write port.

A control instruction carries one 3-bit select field per unit. The field names the register in that unit's bank whose word the unit receives, or leaves the unit idle. The instruction also samples a 24-bit loop register. Its low 12 bits are a repeat count, so the same dispatch goes out on consecutive cycles with no branch in between. Its upper 12 bits belong to the fast-branch counter and are ignored here. While a repeat runs, the block lowers its ready output so that the pipeline front end stalls. On the last issue cycle ready is high again, so the next control instruction is issued on the following cycle. Single-issue instructions can be accepted on every clock.

Top module: `mimd_dispatch`

## Requirements
- R1: After reset, all six `ub_valid` bits are 0, all of `ub_word` is 0, `cmd_ready` is 1, and all twenty-one instruction registers hold 0.
- R2: A clock edge with `ld_en` high, `ld_group` in 0..2 and `ld_index` in 0..6 writes `ld_word` into that register. A load with `ld_group` = 3 or `ld_index` = 7 changes no register.
- R3: Unit u reads bank u/2. Its select field is `cmd_sel[3u+2:3u]`, and a value s in 0..6 puts register s of that bank on `ub_word[10u+9:10u]` with `ub_valid[u]` = 1. Both units of a pair may select the same register or different registers.
- R4: A select value of 7 leaves the unit idle: `ub_valid[u]` = 0 and its `ub_word` slice is 0 for that dispatch.
- R5: A control instruction is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. Its words appear in the cycle after that edge. If no instruction is accepted and no repeat is pending, every `ub_valid` bit is 0 in the next cycle.
- R6: Let N = `loop_reg[11:0]`. For N ≥ 2 the accepted dispatch is presented unchanged for N consecutive cycles. For N = 0 or N = 1 it is presented for one cycle. The largest count, 4095, gives 4095 issues.
- R7: After an instruction with N ≥ 2 is accepted, `cmd_ready` is 0 until the last issue cycle, where it is 1, and any `cmd_valid` in that window is not taken. Instructions with N ≤ 1 can be accepted on back-to-back clocks, each presented for one cycle.
- R8: `loop_reg[23:12]` has no effect on the dispatch or on its repeat length.
- R9: A register load has no effect on a dispatch already accepted, and this also holds for a load on the same edge as the acceptance. The new value is seen by the next accepted instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_en | input | 1 | Instruction register write strobe |
| ld_group | input | 2 | Bank number of the write (0..2) |
| ld_index | input | 3 | Register number within the bank (0..6) |
| ld_word | input | 10 | Word to store |
| cmd_valid | input | 1 | Control instruction present |
| cmd_sel | input | 18 | Per-unit select fields, 3 bits per unit, unit 0 in the low bits; 7 = idle |
| loop_reg | input | 24 | Loop register: bits 11:0 repeat count, bits 23:12 unused here |
| cmd_ready | output | 1 | Front end may issue; low while a repeat is in progress |
| ub_word | output | 60 | Instruction words, 10 bits per unit, unit 0 in the low bits |
| ub_valid | output | 6 | Per-unit valid strobes |

## Verification
On every cycle, the assertions check the following. Outputs stay frozen while ready is low. The valid strobes follow the accepted select fields. An idle unit shows a zero word. The bus goes empty when nothing is accepted. Ready behaves after single and multi-issue acceptances. Some behaviours only the directed scenarios can show. These are the exact repeat length, including the 4095 limit and the masking of the upper loop bits, and the mapping of units to banks and registers. The same holds for discarded writes to bank 3 or index 7, and for a load arriving at the same edge as an acceptance or mid-repeat that stays invisible until the next instruction.

// File: rtl/mimd_dispatch_pkg.sv
package mimd_dispatch_pkg;
  localparam int unsigned WORD_W_D    = 10;
  localparam int unsigned NUM_UNITS_D = 6;
  localparam int unsigned PAIR_D      = 2;
  localparam int unsigned REGS_D      = 7;
  localparam int unsigned CNT_W_D     = 12;
  localparam int unsigned LOOP_W_D    = 24;

  // Number of issues minus one for a given repeat field
  function automatic logic [CNT_W_D-1:0] issues_minus_one(input logic [CNT_W_D-1:0] cnt);
    return (cnt == '0) ? '0 : cnt - 1'b1;
  endfunction
endpackage

// File: rtl/mimd_instr_bank.sv
module mimd_instr_bank #(
  parameter int unsigned WORD_W = 10,
  parameter int unsigned REGS   = 7,
  parameter int unsigned GRP_W  = 2,
  parameter int unsigned SEL_W  = 3,
  parameter int unsigned GID    = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ld_en,
  input  logic [GRP_W-1:0]       ld_group,
  input  logic [SEL_W-1:0]       ld_index,
  input  logic [WORD_W-1:0]      ld_word,
  output logic [REGS*WORD_W-1:0] bank_flat
);
  logic [WORD_W-1:0] regs_q [REGS];
  logic [REGS-1:0]   wr_en;

  always_comb begin
    for (int i = 0; i < REGS; i++) begin
      wr_en[i] = ld_en && (ld_group == GRP_W'(GID)) && (ld_index == SEL_W'(i));
    end
  end

  genvar r;
  generate
    for (r = 0; r < REGS; r++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          regs_q[r] <= '0;
        end else if (wr_en[r]) begin
          regs_q[r] <= ld_word;
        end
      end
      assign bank_flat[r*WORD_W +: WORD_W] = regs_q[r];
    end
  endgenerate
endmodule

// File: rtl/mimd_repeat_ctrl.sv
module mimd_repeat_ctrl
  import mimd_dispatch_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cmd_valid,
  input  logic [CNT_W-1:0] rep_cnt,
  output logic             ready,
  output logic             accept,
  output logic             hold
);
  logic [CNT_W-1:0] rem_q, rem_n;
  logic             rem_en;
  logic [CNT_W-1:0] first_rem;

  assign first_rem = (rep_cnt == '0) ? '0 : rep_cnt - 1'b1;
  assign hold   = (rem_q != '0);
  assign ready  = run && !hold;
  assign accept = cmd_valid && ready;

  always_comb begin
    rem_en = accept || hold;
    if (accept) begin
      rem_n = first_rem;
    end else if (hold) begin
      rem_n = rem_q - 1'b1;
    end else begin
      rem_n = rem_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (rem_en) begin
      rem_q <= rem_n;
    end
  end
endmodule

// File: rtl/mimd_unit_lane.sv
module mimd_unit_lane #(
  parameter int unsigned WORD_W = 10,
  parameter int unsigned REGS   = 7,
  parameter int unsigned SEL_W  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   accept,
  input  logic                   hold,
  input  logic [SEL_W-1:0]       sel,
  input  logic [REGS*WORD_W-1:0] bank_flat,
  output logic [WORD_W-1:0]      word,
  output logic                   valid
);
  logic [WORD_W-1:0] word_q, word_n, picked;
  logic              valid_q, valid_n, sel_ok;
  logic              upd_en;

  assign sel_ok = (sel < SEL_W'(REGS));

  always_comb begin
    picked = '0;
    for (int i = 0; i < REGS; i++) begin
      if (sel == SEL_W'(i)) picked = bank_flat[i*WORD_W +: WORD_W];
    end
  end

  always_comb begin
    upd_en  = !hold;
    valid_n = 1'b0;
    word_n  = '0;
    if (accept) begin
      valid_n = sel_ok;
      word_n  = sel_ok ? picked : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else if (upd_en) begin
      word_q  <= word_n;
      valid_q <= valid_n;
    end
  end

  assign word  = word_q;
  assign valid = valid_q;
endmodule

// File: rtl/mimd_dispatch.sv
module mimd_dispatch
  import mimd_dispatch_pkg::*;
#(
  parameter int unsigned WORD_W    = WORD_W_D,
  parameter int unsigned NUM_UNITS = NUM_UNITS_D,
  parameter int unsigned PAIR      = PAIR_D,
  parameter int unsigned REGS      = REGS_D,
  parameter int unsigned CNT_W     = CNT_W_D,
  parameter int unsigned LOOP_W    = LOOP_W_D,
  localparam int unsigned NUM_GRP  = NUM_UNITS / PAIR,
  localparam int unsigned GRP_W    = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
  localparam int unsigned SEL_W    = $clog2(REGS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ld_en,
  input  logic [GRP_W-1:0]            ld_group,
  input  logic [SEL_W-1:0]            ld_index,
  input  logic [WORD_W-1:0]           ld_word,
  input  logic                        cmd_valid,
  input  logic [NUM_UNITS*SEL_W-1:0]  cmd_sel,
  input  logic [LOOP_W-1:0]           loop_reg,
  output logic                        cmd_ready,
  output logic [NUM_UNITS*WORD_W-1:0] ub_word,
  output logic [NUM_UNITS-1:0]        ub_valid
);
  // Reset synchronizer: asserts asynchronously, releases on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic accept, hold;
  logic unused_branch_bits;
  assign unused_branch_bits = ^loop_reg[LOOP_W-1:CNT_W];

  mimd_repeat_ctrl #(.CNT_W(CNT_W)) u_rep (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .run      (rst_sync_q),
    .cmd_valid(cmd_valid),
    .rep_cnt  (loop_reg[CNT_W-1:0]),
    .ready    (cmd_ready),
    .accept   (accept),
    .hold     (hold)
  );

  logic [REGS*WORD_W-1:0] bank_flat [NUM_GRP];

  genvar g, u;
  generate
    for (g = 0; g < NUM_GRP; g++) begin : g_bank
      mimd_instr_bank #(
        .WORD_W(WORD_W), .REGS(REGS), .GRP_W(GRP_W), .SEL_W(SEL_W), .GID(g)
      ) u_bank (
        .clk      (clk),
        .rst_n    (rst_sync_q),
        .ld_en    (ld_en),
        .ld_group (ld_group),
        .ld_index (ld_index),
        .ld_word  (ld_word),
        .bank_flat(bank_flat[g])
      );
    end

    for (u = 0; u < NUM_UNITS; u++) begin : g_lane
      mimd_unit_lane #(.WORD_W(WORD_W), .REGS(REGS), .SEL_W(SEL_W)) u_lane (
        .clk      (clk),
        .rst_n    (rst_sync_q),
        .accept   (accept),
        .hold     (hold),
        .sel      (cmd_sel[u*SEL_W +: SEL_W]),
        .bank_flat(bank_flat[u / PAIR]),
        .word     (ub_word[u*WORD_W +: WORD_W]),
        .valid    (ub_valid[u])
      );
    end
  endgenerate
endmodule

// File: rtl/mimd_dispatch_chk.sv
module mimd_dispatch_chk #(
  parameter int unsigned WORD_W    = 10,
  parameter int unsigned NUM_UNITS = 6,
  parameter int unsigned REGS      = 7,
  parameter int unsigned CNT_W     = 12,
  parameter int unsigned LOOP_W    = 24,
  parameter int unsigned SEL_W     = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cmd_valid,
  input logic [NUM_UNITS*SEL_W-1:0]  cmd_sel,
  input logic [LOOP_W-1:0]           loop_reg,
  input logic                        cmd_ready,
  input logic [NUM_UNITS*WORD_W-1:0] ub_word,
  input logic [NUM_UNITS-1:0]        ub_valid
);
  logic taken, multi;
  assign taken = cmd_valid && cmd_ready;
  assign multi = (loop_reg[CNT_W-1:0] > CNT_W'(1));

  // R6: a pending repeat keeps every output frozen
  assert_hold_while_stalled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |=> ($stable(ub_valid) && $stable(ub_word)));

  // R5: nothing accepted and nothing pending empties the bus
  assert_idle_after_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && !cmd_valid) |=> (ub_valid == '0));

  // R7: single-issue acceptance keeps the front end running
  assert_single_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !multi) |=> cmd_ready);

  // R7: multi-issue acceptance stalls the front end
  assert_multi_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && multi) |=> !cmd_ready);

  genvar u;
  generate
    for (u = 0; u < NUM_UNITS; u++) begin : g_u
      // R3: the strobe follows the accepted select field
      assert_valid_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> (ub_valid[u] == ($past(cmd_sel[u*SEL_W +: SEL_W]) < SEL_W'(REGS))));
      // R4: an idle unit carries a zero word
      assert_idle_word_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ub_valid[u] |-> (ub_word[u*WORD_W +: WORD_W] == '0));
    end
  endgenerate
endmodule

bind mimd_dispatch mimd_dispatch_chk #(
  .WORD_W(WORD_W), .NUM_UNITS(NUM_UNITS), .REGS(REGS),
  .CNT_W(CNT_W), .LOOP_W(LOOP_W), .SEL_W(SEL_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_valid(cmd_valid),
  .cmd_sel  (cmd_sel),
  .loop_reg (loop_reg),
  .cmd_ready(cmd_ready),
  .ub_word  (ub_word),
  .ub_valid (ub_valid)
);

// File: tb/mimd_dispatch_test.sv
`timescale 1ns/1ps
module mimd_dispatch_test;
  logic        clk;
  logic        rst_n;
  logic        ld_en;
  logic [1:0]  ld_group;
  logic [2:0]  ld_index;
  logic [9:0]  ld_word;
  logic        cmd_valid;
  logic [17:0] cmd_sel;
  logic [23:0] loop_reg;
  logic        cmd_ready;
  logic [59:0] ub_word;
  logic [5:0]  ub_valid;

  int n_chk  = 0;
  int n_fail = 0;
  logic [9:0] mdl [3][7];

  mimd_dispatch uut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_group(ld_group),
    .ld_index(ld_index), .ld_word(ld_word), .cmd_valid(cmd_valid),
    .cmd_sel(cmd_sel), .loop_reg(loop_reg), .cmd_ready(cmd_ready),
    .ub_word(ub_word), .ub_valid(ub_valid)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [65:0] act, input logic [65:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [65:0] exp_bus(input logic [17:0] sel);
    logic [65:0] e;
    e = '0;
    for (int u = 0; u < 6; u++) begin
      logic [2:0] s;
      s = sel[u*3 +: 3];
      if (s != 3'd7) begin
        e[60+u] = 1'b1;
        e[u*10 +: 10] = mdl[u/2][s];
      end
    end
    return e;
  endfunction

  function automatic logic [17:0] same_sel(input logic [2:0] s);
    return {6{s}};
  endfunction

  task automatic load(input logic [1:0] g, input logic [2:0] i, input logic [9:0] w);
    @(negedge clk);
    ld_en = 1'b1; ld_group = g; ld_index = i; ld_word = w;
    @(negedge clk);
    ld_en = 1'b0;
    if (g < 2'd3 && i < 3'd7) mdl[g][i] = w;
  endtask

  task automatic run_cmd(input logic [17:0] sel, input logic [23:0] lv,
                         input int n, input string tag);
    logic [65:0] e;
    e = exp_bus(sel);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_sel = sel; loop_reg = lv;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      chk({tag, " word"}, {ub_valid, ub_word}, e);
      chk({tag, " ready"}, {65'd0, cmd_ready}, {65'd0, (k == n - 1)});
      if (k < n - 1) @(negedge clk);
    end
    @(negedge clk);
    chk({tag, " empty after"}, {ub_valid, ub_word}, 66'd0);
  endtask

  task automatic dump_all(input string tag);
    for (int i = 0; i < 7; i++) run_cmd(same_sel(3'(i)), 24'd1, 1, tag);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 outputs", {ub_valid, ub_word}, 66'd0);
    chk("R1 ready", {65'd0, cmd_ready}, {65'd0, 1'b1});
    dump_all("R1 registers zero");
  endtask

  task automatic t_load_map;
    for (int g = 0; g < 3; g++)
      for (int i = 0; i < 7; i++)
        load(2'(g), 3'(i), 10'(g * 97 + i * 13 + 5));
    dump_all("R2 R3 loaded words");
  endtask

  task automatic t_ignored_loads;
    load(2'd3, 3'd0, 10'h3FF);
    load(2'd3, 3'd6, 10'h2AA);
    load(2'd1, 3'd7, 10'h155);
    dump_all("R2 bank3 or index7 ignored");
  endtask

  task automatic t_mixed_sel;
    // units 0..5 select 6,0,3,7,7,2
    run_cmd({3'd2, 3'd7, 3'd7, 3'd3, 3'd0, 3'd6}, 24'd1, 1, "R3 R4 mixed selects");
    // pair shares one register, others differ
    run_cmd({3'd7, 3'd5, 3'd4, 3'd4, 3'd1, 3'd1}, 24'd0, 1, "R3 shared register");
    run_cmd(same_sel(3'd7), 24'd1, 1, "R4 all idle");
  endtask

  task automatic t_repeat;
    run_cmd({3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6}, 24'd4, 4, "R6 R7 repeat 4");
    run_cmd(same_sel(3'd3), 24'd2, 2, "R6 repeat 2");
    run_cmd(same_sel(3'd0), 24'd0, 1, "R6 count zero");
    run_cmd(same_sel(3'd6), 24'hFFF000, 1, "R8 upper bits only");
    run_cmd({3'd0, 3'd7, 3'd6, 3'd2, 3'd7, 3'd5}, 24'hABCFFF, 4095, "R6 R8 max count");
  endtask

  task automatic t_back_to_back;
    logic [17:0] s1, s2;
    logic [65:0] e1, e2;
    s1 = same_sel(3'd2);
    s2 = {3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5};
    e1 = exp_bus(s1); e2 = exp_bus(s2);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_sel = s1; loop_reg = 24'd1;
    @(negedge clk);
    cmd_sel = s2; loop_reg = 24'd0;
    chk("R7 back-to-back first", {ub_valid, ub_word}, e1);
    chk("R7 back-to-back ready", {65'd0, cmd_ready}, {65'd0, 1'b1});
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R7 back-to-back second", {ub_valid, ub_word}, e2);
    @(negedge clk);
    chk("R5 empty after pair", {ub_valid, ub_word}, 66'd0);
  endtask

  task automatic t_stall_ignores_cmd;
    logic [65:0] e1, e2;
    e1 = exp_bus(same_sel(3'd4));
    e2 = exp_bus(same_sel(3'd1));
    @(negedge clk);
    cmd_valid = 1'b1; cmd_sel = same_sel(3'd4); loop_reg = 24'd3;
    @(negedge clk);
    cmd_sel = same_sel(3'd1); loop_reg = 24'd1;  // held while stalled
    chk("R7 stalled issue1", {ub_valid, ub_word}, e1);
    @(negedge clk);
    chk("R7 stalled issue2", {ub_valid, ub_word}, e1);
    @(negedge clk);
    chk("R7 stalled issue3", {ub_valid, ub_word}, e1);
    chk("R7 ready on last", {65'd0, cmd_ready}, {65'd0, 1'b1});
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R7 held cmd after last", {ub_valid, ub_word}, e2);
    @(negedge clk);
    chk("R5 empty after held", {ub_valid, ub_word}, 66'd0);
  endtask

  task automatic t_load_in_flight;
    logic [65:0] e_old;
    load(2'd0, 3'd0, 10'h111);
    e_old = exp_bus(same_sel(3'd0));
    @(negedge clk);
    cmd_valid = 1'b1; cmd_sel = same_sel(3'd0); loop_reg = 24'd4;
    ld_en = 1'b1; ld_group = 2'd0; ld_index = 3'd0; ld_word = 10'h222;
    @(negedge clk);
    cmd_valid = 1'b0; ld_en = 1'b0;
    chk("R9 same-edge load unseen", {ub_valid, ub_word}, e_old);
    @(negedge clk);
    chk("R9 issue2", {ub_valid, ub_word}, e_old);
    ld_en = 1'b1; ld_group = 2'd0; ld_index = 3'd0; ld_word = 10'h333;
    @(negedge clk);
    ld_en = 1'b0;
    chk("R9 mid-repeat load unseen", {ub_valid, ub_word}, e_old);
    @(negedge clk);
    chk("R9 issue4", {ub_valid, ub_word}, e_old);
    @(negedge clk);
    chk("R9 empty after", {ub_valid, ub_word}, 66'd0);
    mdl[0][0] = 10'h333;
    run_cmd(same_sel(3'd0), 24'd1, 1, "R9 next command sees load");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int g = 0; g < 3; g++)
      for (int i = 0; i < 7; i++) mdl[g][i] = '0;
    rst_n = 1'b0; ld_en = 1'b0; ld_group = '0; ld_index = '0; ld_word = '0;
    cmd_valid = 1'b0; cmd_sel = '0; loop_reg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_load_map;
    t_ignored_loads;
    t_mixed_sel;
    t_repeat;
    t_back_to_back;
    t_stall_ignores_cmd;
    t_load_in_flight;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule